// File: doc/BRIEF.md
# Hard-Decision Viterbi Decoder Core (K=3, Rate 1/2)

This core decodes a rate-1/2, constraint-length-3 convolutional code from one hard-decision symbol pair per clock. The code uses generators 5 and 7 octal, and the trellis has four states. Each state has its own add-compare-select unit. For each cycle the unit forms the Hamming distance from the received pair to the pair expected on each of its two incoming branches, adds that distance to the predecessor's path metric and keeps the better candidate. It passes the chosen branch on as a decision bit. Path metrics are narrow and wrap around, and they are compared modulo their width, so no normalisation subtractor is needed.

The survivor memory uses register exchange. Every state holds a shift register of decoded bits. Each cycle, every state copies the history of its chosen predecessor and appends its own input bit. The oldest bit of each state's history forms a 4-bit decoded column, which is presented every cycle. Downstream logic votes on this column with (col[3] & col[2]) | (col[1] & col[0]).

A pulse on the sync input is registered into an initialise cycle. In that cycle the metrics are loaded to favour state 0, the survivor histories are cleared and the received pair is discarded. The first symbol of the burst is expected in the following cycle.

Top module: `vd_core`

## Requirements
- R1: The trellis state index is {b(n-1), b(n-2)}. rx_pair_i[1] carries y2 = b ^ b(n-2) and rx_pair_i[0] carries y1 = b ^ b(n-1) ^ b(n-2), where b is the source bit of the current symbol.
- R2: While rst_n is low, col_o is 4'b0000. After reset, with no sync and an all-zero received stream, col_o stays 4'b0000.
- R3: Path metrics are PM_W bits wide and are compared modulo 2^PM_W. The signed difference between any two state metrics never exceeds 2^(PM_W-1)-3. Decoding stays correct after any length of operation, including long stretches of random symbols.
- R4: A sync_i sampled high at a clock edge makes the next cycle an initialise cycle. At the end of that cycle, state 0's metric is loaded with 0 and every other state's metric with INIT_PM, all survivor histories are cleared, and the received pair of that cycle has no effect. The first burst symbol is the one sampled at the following edge.
- R5: col_o is 4'b0000 for the SURV_DEPTH cycles that start at the initialise edge, whatever symbols arrive in that time.
- R6: col_o[s] is the oldest bit of state s's survivor. The decision for burst symbol k (k = 0 first) is on col_o in the cycle after edge number k+SURV_DEPTH counted from the initialise edge. With the default depth of 11, the first meaningful column therefore appears 11 cycles after initialisation. For an error-free burst, all four column bits equal source bit k.
- R7: With isolated single-bit symbol errors at least 24 symbols apart, the majority bit (col[3]&col[2])|(col[1]&col[0]) equals the source bit at the latency given in R6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all registers update on its rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| sync_i | input | 1 | Burst start pulse; registered into the initialise cycle |
| rx_pair_i | input | 2 | Received hard-decision pair, bit 1 = y2, bit 0 = y1 |
| col_o | output | 4 | Decoded column, bit s = oldest survivor bit of state s |

## Verification
The assertions assume that rst_n is released in step with clk and that rx_pair_i and sync_i always carry defined binary values. The metric spread bound also assumes that INIT_PM leaves at least two units of headroom below the limit. The bench drives its inputs at the falling edge, releases reset there, and holds every input at 0 or 1 at all times, including the random-noise stretches that push metric spread and wrap-around hardest. Each sync is a one-cycle pulse followed by one junk pair for the discarded initialise cycle.

// File: rtl/vd_pkg.sv
package vd_pkg;

  localparam int CONSTR_LEN = 3;
  localparam int SW         = CONSTR_LEN - 1;
  localparam int NSTATE     = 1 << SW;

  // received / expected pair, bit 1 = y2, bit 0 = y1
  typedef logic [1:0] pair_t;
  // Hamming distance of a pair, 0..2
  typedef logic [1:0] bm_t;

  // Expected pair on the branch into state ns from predecessor {ns[0], x}.
  // Input bit of that branch is ns[1].
  function automatic pair_t branch_pair(input logic [SW-1:0] ns, input logic x);
    logic b;
    b = ns[SW-1];
    return {b ^ x, b ^ ns[0] ^ x};
  endfunction

  function automatic bm_t pair_distance(input pair_t a, input pair_t b);
    pair_t d;
    d = a ^ b;
    return {d[1] & d[0], d[1] ^ d[0]};
  endfunction

endpackage

// File: rtl/vd_bmu.sv
module vd_bmu
  import vd_pkg::*;
(
  input  pair_t                   rx_i,
  output bm_t [NSTATE-1:0][1:0]   bm_o
);

  for (genvar s = 0; s < NSTATE; s++) begin : g_state
    localparam logic [SW-1:0] NS = SW'(s);
    for (genvar x = 0; x < 2; x++) begin : g_branch
      localparam logic XB = (x != 0);
      assign bm_o[s][x] = pair_distance(rx_i, branch_pair(NS, XB));
    end
  end

endmodule

// File: rtl/vd_acs.sv
module vd_acs
  import vd_pkg::*;
#(
  parameter int PM_W      = 5,
  parameter int INIT_PM   = 8,
  parameter int STATE_IDX = 0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            init_i,
  input  logic [PM_W-1:0] pm0_i,
  input  logic [PM_W-1:0] pm1_i,
  input  bm_t             bm0_i,
  input  bm_t             bm1_i,
  output logic [PM_W-1:0] pm_o,
  output logic            dec_o
);

  localparam logic [PM_W-1:0] LOAD_PM = (STATE_IDX == 0) ? '0 : PM_W'(INIT_PM);

  logic [PM_W-1:0] cand0, cand1, diff, pm_d, pm_q;
  logic            take1;

  // candidate sums wrap; ordering is taken from the sign of the wrapped difference
  always_comb begin
    cand0 = pm0_i + PM_W'(bm0_i);
    cand1 = pm1_i + PM_W'(bm1_i);
    diff  = cand1 - cand0;
    take1 = diff[PM_W-1];            // strict: a tie keeps predecessor 0
    if (init_i) pm_d = LOAD_PM;
    else        pm_d = take1 ? cand1 : cand0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pm_q <= LOAD_PM;
    else        pm_q <= pm_d;
  end

  assign pm_o  = pm_q;
  assign dec_o = take1;

endmodule

// File: rtl/vd_survivor.sv
module vd_survivor
  import vd_pkg::*;
#(
  parameter int DEPTH = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              init_i,
  input  logic [NSTATE-1:0] dec_i,
  output logic [NSTATE-1:0] col_o
);

  logic [DEPTH-1:0] hist_q [NSTATE];
  logic [DEPTH-1:0] hist_d [NSTATE];

  for (genvar s = 0; s < NSTATE; s++) begin : g_exch
    localparam int   P0  = (2 * s) % NSTATE;
    localparam int   P1  = P0 + 1;
    localparam logic BIT = (s >= NSTATE / 2);
    assign hist_d[s] = init_i   ? '0 :
                       dec_i[s] ? {hist_q[P1][DEPTH-2:0], BIT} :
                                  {hist_q[P0][DEPTH-2:0], BIT};
    assign col_o[s]  = hist_q[s][DEPTH-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NSTATE; i++) hist_q[i] <= '0;
    end else begin
      for (int i = 0; i < NSTATE; i++) hist_q[i] <= hist_d[i];
    end
  end

endmodule

// File: rtl/vd_core.sv
module vd_core
  import vd_pkg::*;
#(
  parameter int PM_W       = 5,
  parameter int INIT_PM    = 8,
  parameter int SURV_DEPTH = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sync_i,
  input  logic [1:0]        rx_pair_i,
  output logic [NSTATE-1:0] col_o
);

  logic                  init_q, init_d;
  logic [PM_W-1:0]       pm [NSTATE];
  logic [NSTATE-1:0]     dec;
  bm_t [NSTATE-1:0][1:0] bm;

  assign init_d = sync_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) init_q <= 1'b0;
    else        init_q <= init_d;
  end

  vd_bmu i_bmu (
    .rx_i (rx_pair_i),
    .bm_o (bm)
  );

  for (genvar s = 0; s < NSTATE; s++) begin : g_acs
    localparam int P0 = (2 * s) % NSTATE;
    localparam int P1 = P0 + 1;
    vd_acs #(
      .PM_W      (PM_W),
      .INIT_PM   (INIT_PM),
      .STATE_IDX (s)
    ) i_acs (
      .clk    (clk),
      .rst_n  (rst_n),
      .init_i (init_q),
      .pm0_i  (pm[P0]),
      .pm1_i  (pm[P1]),
      .bm0_i  (bm[s][0]),
      .bm1_i  (bm[s][1]),
      .pm_o   (pm[s]),
      .dec_o  (dec[s])
    );
  end

  vd_survivor #(
    .DEPTH (SURV_DEPTH)
  ) i_surv (
    .clk    (clk),
    .rst_n  (rst_n),
    .init_i (init_q),
    .dec_i  (dec),
    .col_o  (col_o)
  );

endmodule

// File: rtl/vd_core_chk.sv
module vd_core_chk
  import vd_pkg::*;
#(
  parameter int PM_W       = 5,
  parameter int INIT_PM    = 8,
  parameter int SURV_DEPTH = 11
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sync_i,
  input logic              init_q,
  input logic [NSTATE-1:0] col_o,
  input logic [PM_W-1:0]   pm [NSTATE]
);

  localparam int CW = $clog2(SURV_DEPTH + 1);
  localparam logic signed [PM_W-1:0] LIM = PM_W'(2 ** (PM_W - 1) - 3);

  logic          spread_ok;
  logic          pm_is_load;
  logic [CW-1:0] zero_left;

  always_comb begin
    spread_ok = 1'b1;
    for (int i = 0; i < NSTATE; i++) begin
      for (int j = 0; j < NSTATE; j++) begin
        logic [PM_W-1:0] d;
        d = pm[i] - pm[j];
        if ($signed(d) > LIM) spread_ok = 1'b0;
      end
    end
  end

  always_comb begin
    pm_is_load = (pm[0] == '0);
    for (int i = 1; i < NSTATE; i++)
      if (pm[i] != PM_W'(INIT_PM)) pm_is_load = 1'b0;
  end

  // cycles left in which the cleared histories must still show on col_o
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              zero_left <= '0;
    else if (init_q)         zero_left <= CW'(SURV_DEPTH);
    else if (zero_left != 0) zero_left <= zero_left - 1'b1;
  end

  a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    spread_ok);

  a_r4_sync_opens_init: assert property (@(posedge clk) disable iff (!rst_n)
    sync_i |=> init_q);

  a_r4_init_needs_sync: assert property (@(posedge clk) disable iff (!rst_n)
    !sync_i |=> !init_q);

  a_r4_metric_load: assert property (@(posedge clk) disable iff (!rst_n)
    init_q |=> pm_is_load);

  a_r5_column_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    (zero_left != 0) |-> (col_o == '0));

endmodule

bind vd_core vd_core_chk #(
  .PM_W       (PM_W),
  .INIT_PM    (INIT_PM),
  .SURV_DEPTH (SURV_DEPTH)
) i_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .sync_i (sync_i),
  .init_q (init_q),
  .col_o  (col_o),
  .pm     (pm)
);

// File: tb/test_vd_core.sv
module test_vd_core;

  localparam int DEPTH = 11;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       sync;
  logic [1:0] rx;
  logic [3:0] col;

  int  n_cmp = 0;
  int  n_bad = 0;
  bit  src [0:1023];
  bit  e1, e0;
  logic [6:0] lfsr;

  always #4 clk = ~clk;

  vd_core #(.PM_W(5), .INIT_PM(8), .SURV_DEPTH(DEPTH)) i_vd_core (
    .clk       (clk),
    .rst_n     (rst_n),
    .sync_i    (sync),
    .rx_pair_i (rx),
    .col_o     (col)
  );

  task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: col actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic vote(input logic [3:0] c);
    return (c[3] & c[2]) | (c[1] & c[0]);
  endfunction

  function automatic logic [1:0] encode(input bit b);
    logic [1:0] p;
    p  = {b ^ e0, b ^ e1 ^ e0};
    e0 = e1;
    e1 = b;
    return p;
  endfunction

  function automatic bit next_src(input int mode, input int k);
    bit b;
    case (mode)
      0: begin b = lfsr[6]; lfsr = {lfsr[5:0], lfsr[6] ^ lfsr[5]}; end
      1: b = 1'b0;
      2: b = 1'b1;
      default: b = k[0];
    endcase
    return b;
  endfunction

  // mode: 0 lfsr, 1 zeros, 2 ones, 3 alternating; espace 0 = no errors
  task automatic run_burst(input int n, input int mode, input logic [6:0] seed,
                           input int espace, input int eoff, input string first_tag);
    lfsr = seed;
    e1 = 1'b0;
    e0 = 1'b0;
    @(negedge clk); sync = 1'b1; rx = 2'($urandom);
    @(negedge clk); sync = 1'b0; rx = 2'($urandom);   // initialise cycle: junk pair
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      if (k < DEPTH) begin
        check("R5 cleared column", col, 4'b0000);
      end else if (espace == 0) begin
        if (k < DEPTH + 8) check(first_tag, col, {4{src[k-DEPTH]}});
        else               check("R6 error-free column", col, {4{src[k-DEPTH]}});
      end else begin
        check("R7 majority with errors", {3'b000, vote(col)}, {3'b000, src[k-DEPTH]});
      end
      src[k] = next_src(mode, k);
      rx = encode(src[k]);
      if (espace > 0 && (k % espace) == eoff)
        rx[(k / espace) % 2] = ~rx[(k / espace) % 2];
    end
  endtask

  task automatic run_noise_then_lock();
    for (int k = 0; k < 800; k++) begin
      @(negedge clk);
      rx = 2'($urandom);
    end
    lfsr = 7'h2D;
    for (int k = 0; k < 200; k++) begin
      @(negedge clk);
      if (k >= 40) check("R3 decode after long noise", col, {4{src[k-DEPTH]}});
      src[k] = next_src(0, k);
      rx = encode(src[k]);
    end
  endtask

  initial begin
    rst_n = 1'b0;
    sync  = 1'b0;
    rx    = 2'b00;
    repeat (3) @(negedge clk);
    check("R2 column in reset", col, 4'b0000);
    rst_n = 1'b1;
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      check("R2 column after reset", col, 4'b0000);
    end
    run_burst(160, 0, 7'h01, 0, 0, "R1 trellis convention");
    run_burst(60, 2, 7'h01, 0, 0, "R4 resync, init pair ignored");
    run_burst(40, 1, 7'h01, 0, 0, "R6 zeros");
    run_burst(200, 0, 7'h5A, 24, 5, "R7");
    run_burst(120, 0, 7'h33, 24, 0, "R7");
    run_burst(60, 3, 7'h01, 0, 0, "R1 alternating");
    run_noise_then_lock();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(8 * 150000);
    n_bad++;
    $display("FAIL watchdog: run did not finish, actual running expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule